// File: doc/BRIEF.md
# Prescaled PWM Time Base

This block produces the timing reference for a pulse-width modulator: a 16-bit counter that steps once per prescaled tick and sweeps between zero and a programmable period. The tick comes from a two-stage divider whose ratio is the product of a high-speed stage (1, 2, 4 ... 14) and a binary stage (1, 2, 4 ... 128). Every design register is clocked by the system clock; the tick is only an enable.

Software sets a 16-bit control word and a period word through two write strobes. The control word picks the count direction (up, down, up-then-down, or hold), how the counter stops, whether a period write takes effect at once or waits in a shadow copy until the counter reaches zero, and the two divider codes. Downstream compare and output logic consume the counter value, a direction flag and two single-cycle events, one on a live tick at zero and one on a live tick at the period.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, both events are low, the direction flag is low, the control word is 0 and the active period is 0.
- R2: Control bits 9:7 hold a code h and bits 12:10 a code c; a tick occurs once every (h==0 ? 1 : 2*h) * 2^c system cycles, and the counter changes only at the end of a tick cycle.
- R3: With control bits 1:0 = 00 the counter steps up by one per live tick and, on a tick where it is at or above the period, goes to 0.
- R4: With control bits 1:0 = 01 the counter steps down by one per live tick and, on a tick at 0, reloads the active period; the direction flag is 1.
- R5: With control bits 1:0 = 10 the counter rises to the period, then falls to 0, and repeats; the direction flag is 1 while falling and 0 while rising, and it turns on the tick at the period and the tick at 0.
- R6: With control bits 1:0 = 11 the counter holds its value and no event is issued.
- R7: Control bits 15:14 = 00 keep the counter still; 01 lets it run until a tick moves it onto 0 and then keeps it there until the next control write; 10 and 11 let it run without end.
- R8: With control bit 3 = 1 a period write updates the active period at once; with bit 3 = 0 it updates only the shadow copy, which moves into the active period on the live tick where the counter is 0.
- R9: The zero event is high for exactly the live-tick cycle where the counter is 0, and the period event for the live-tick cycle where the counter equals the active period; neither fires without a tick.
- R10: Every control write restarts the prescaler, so the first tick after a write comes a full ratio of cycles after the write cycle, and no tick occurs in the write cycle itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word data |
| prd_wr | input | 1 | Write strobe for the period word |
| prd_wdata | input | 16 | Period word data |
| cnt | output | 16 | Current counter value |
| evt_zero | output | 1 | Live tick with counter at zero |
| evt_period | output | 1 | Live tick with counter at the active period |
| dir_down | output | 1 | Counting direction, 1 when falling |

## Verification
A write taken at one clock edge is visible from the next cycle on; the events and the direction flag are combinational on registered state, so they are due in the very cycle the tick fires, and the counter value changes one cycle after that tick. The bench drives inputs just after a rising edge and compares all four outputs against its behavioural model at every falling edge, so each result is read in the cycle it is due. Tick spacing, shadow transfer and stop behaviour are also measured directly by counting cycles between counter changes and by recording the counter at each period event.

// File: rtl/pwm_tbase_pkg.sv
// Package: shared types of the prescaled time base.
// Assumes a fixed 16-bit control word; reserved bits are stored but unused.
package pwm_tbase_pkg;

    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_HOLD = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RUN_HALT_NOW = 2'b00,
        RUN_TO_END   = 2'b01,
        RUN_FREE_ALT = 2'b10,
        RUN_FREE     = 2'b11
    } run_mode_e;

    typedef struct packed {
        run_mode_e  run;        // 15:14
        logic       spare13;    // 13
        logic [2:0] lo_div;     // 12:10
        logic [2:0] hs_div;     // 9:7
        logic [2:0] spare6_4;   // 6:4
        logic       prd_direct; // 3
        logic       spare2;     // 2
        cnt_mode_e  mode;       // 1:0
    } tb_ctl_t;

endpackage

// File: rtl/pwm_tbase_prescale.sv
// Module: two-stage prescaler producing a one-cycle tick enable.
// Ratio = (hs_code==0 ? 1 : 2*hs_code) * 2**lo_code. A restart pulse clears
// the divider and suppresses the tick in that cycle. Assumes codes are stable
// except in a restart cycle.
module pwm_tbase_prescale #(
    parameter int HS_W = 3,
    parameter int LO_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [HS_W-1:0] hs_code,
    input  logic [LO_W-1:0] lo_code,
    output logic            tick
);
    localparam int RATIO_W = HS_W + 1 + (2 ** LO_W) - 1;

    logic [RATIO_W-1:0] stage1;
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] div_cnt;

    // Combined division ratio from the two codes.
    always_comb begin
        stage1 = (hs_code == '0) ? RATIO_W'(1) : RATIO_W'({hs_code, 1'b0});
        ratio  = stage1 << lo_code;
    end

    // Tick on the last cycle of each ratio window, never during a restart.
    always_comb tick = !restart && (div_cnt >= ratio - RATIO_W'(1));

    // Divider counter: cleared on restart or tick, otherwise counts.
    always_ff @(posedge clk) begin
        if (!rst_n)               div_cnt <= '0;
        else if (restart || tick) div_cnt <= '0;
        else                      div_cnt <= div_cnt + RATIO_W'(1);
    end
endmodule

// File: rtl/pwm_tbase_period.sv
// Module: period register with shadow copy.
// Direct mode writes both copies; shadow mode writes only the shadow,
// which moves to the active copy on a zero load strobe.
module pwm_tbase_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             direct,
    input  logic             zero_load,
    output logic [CNT_W-1:0] prd_act
);
    logic [CNT_W-1:0] shadow_q;

    // Shadow copy always takes the written value.
    always_ff @(posedge clk) begin
        if (!rst_n)  shadow_q <= '0;
        else if (wr) shadow_q <= wdata;
    end

    // Active copy: direct write, or shadow transfer at a zero tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                      prd_act <= '0;
        else if (wr && direct)           prd_act <= wdata;
        else if (zero_load && !direct)   prd_act <= shadow_q;
    end
endmodule

// File: rtl/pwm_tbase_counter.sv
// Module: counter core of the time base.
// Steps on live ticks in up, down or up-down mode, handles stop modes and
// raises zero/period events. Assumes tick is low in a control write cycle.
module pwm_tbase_counter
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctl_wr,
    input  cnt_mode_e        mode,
    input  run_mode_e        run,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             evt_zero,
    output logic             evt_period,
    output logic             zero_load
);
    logic             advance;
    logic             halted_q;
    logic             ud_down_q;
    logic             ud_nx;
    logic [CNT_W-1:0] cnt_nx;

    // A tick is live only when not frozen, not stopped and not halted.
    always_comb advance = tick && (mode != MODE_HOLD) && (run != RUN_HALT_NOW) && !halted_q;

    // Next counter value and up-down direction per mode.
    always_comb begin
        cnt_nx = cnt;
        ud_nx  = ud_down_q;
        unique case (mode)
            MODE_UP:   cnt_nx = (cnt >= prd) ? '0 : cnt + CNT_W'(1);
            MODE_DOWN: cnt_nx = (cnt == '0) ? prd : cnt - CNT_W'(1);
            MODE_UPDN: begin
                if (!ud_down_q) begin
                    if (cnt >= prd) begin
                        ud_nx  = 1'b1;
                        cnt_nx = (cnt == '0) ? '0 : cnt - CNT_W'(1);
                    end else begin
                        cnt_nx = cnt + CNT_W'(1);
                    end
                end else begin
                    if (cnt == '0) begin
                        ud_nx  = 1'b0;
                        cnt_nx = (prd == '0) ? '0 : CNT_W'(1);
                    end else begin
                        cnt_nx = cnt - CNT_W'(1);
                    end
                end
            end
            default: cnt_nx = cnt;
        endcase
    end

    // Counter and up-down direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            ud_down_q <= 1'b0;
        end else if (advance) begin
            cnt       <= cnt_nx;
            ud_down_q <= ud_nx;
        end
    end

    // Halt latch for run-to-end mode, cleared by any control write.
    always_ff @(posedge clk) begin
        if (!rst_n)      halted_q <= 1'b0;
        else if (ctl_wr) halted_q <= 1'b0;
        else if (advance && (run == RUN_TO_END) && (cnt_nx == '0)) halted_q <= 1'b1;
    end

    // Events and direction flag.
    always_comb begin
        evt_zero   = advance && (cnt == '0);
        evt_period = advance && (cnt == prd);
        zero_load  = evt_zero;
        dir_down   = (mode == MODE_DOWN) ? 1'b1 : (mode == MODE_UP) ? 1'b0 : ud_down_q;
    end
endmodule

// File: rtl/pwm_timebase.sv
// Module: top of the prescaled PWM time base.
// Holds the control word and ties prescaler, period register and counter.
// Assumes writes are single-cycle strobes on the system clock.
module pwm_timebase
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [15:0]      ctl_wdata,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             evt_zero,
    output logic             evt_period,
    output logic             dir_down
);
    tb_ctl_t          ctl_q;
    logic             presc_tick;
    logic             zero_load;
    logic [CNT_W-1:0] prd_active;

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= tb_ctl_t'(ctl_wdata);
    end

    pwm_tbase_prescale #(.HS_W(3), .LO_W(3)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctl_wr),
        .hs_code (ctl_q.hs_div),
        .lo_code (ctl_q.lo_div),
        .tick    (presc_tick)
    );

    pwm_tbase_period #(.CNT_W(CNT_W)) u_prd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (prd_wr),
        .wdata     (prd_wdata),
        .direct    (ctl_q.prd_direct),
        .zero_load (zero_load),
        .prd_act   (prd_active)
    );

    pwm_tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (presc_tick),
        .ctl_wr     (ctl_wr),
        .mode       (ctl_q.mode),
        .run        (ctl_q.run),
        .prd        (prd_active),
        .cnt        (cnt),
        .dir_down   (dir_down),
        .evt_zero   (evt_zero),
        .evt_period (evt_period),
        .zero_load  (zero_load)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
// Module: assertion checker bound to pwm_timebase.
module pwm_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic [5:0]       wdiv_bits,
    input logic             prd_wr,
    input logic [CNT_W-1:0] prd_wdata,
    input logic [1:0]       mode_bits,
    input logic [1:0]       run_bits,
    input logic [5:0]       div_bits,
    input logic             direct_bit,
    input logic             tick,
    input logic [CNT_W-1:0] prd_act,
    input logic [CNT_W-1:0] cnt,
    input logic             evt_zero,
    input logic             evt_period
);
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_bits != 6'd0) |=> !tick);

    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdiv_bits != 6'd0) |=> !tick);

    assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == 2'b00) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1) || cnt == '0));

    assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == 2'b01) |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1) || cnt == $past(prd_act)));

    assert_freeze_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == 2'b11) |=> $stable(cnt));

    assert_halt_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_bits == 2'b00) |=> $stable(cnt));

    assert_direct_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_wr && direct_bit) |=> (prd_act == $past(prd_wdata)));

    assert_event_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_zero || evt_period) |-> tick);
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .wdiv_bits  (ctl_wdata[12:7]),
    .prd_wr     (prd_wr),
    .prd_wdata  (prd_wdata),
    .mode_bits  (ctl_q.mode),
    .run_bits   (ctl_q.run),
    .div_bits   ({ctl_q.lo_div, ctl_q.hs_div}),
    .direct_bit (ctl_q.prd_direct),
    .tick       (presc_tick),
    .prd_act    (prd_active),
    .cnt        (cnt),
    .evt_zero   (evt_zero),
    .evt_period (evt_period)
);

// File: tb/pwm_timebase_test.sv
`timescale 1ns/1ps
module pwm_timebase_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        prd_wr = 1'b0;
    logic [15:0] prd_wdata = '0;
    logic [15:0] cnt;
    logic        evt_zero, evt_period, dir_down;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";

    pwm_timebase uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .prd_wr(prd_wr), .prd_wdata(prd_wdata), .cnt(cnt),
        .evt_zero(evt_zero), .evt_period(evt_period), .dir_down(dir_down)
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit m_valid = 0;
    int m_ctl, m_pre, m_sh, m_act, m_cnt, m_ud, m_halt;
    int n_ctl, n_pre, n_sh, n_act, n_cnt, n_ud, n_halt;

    always @(negedge clk) begin
        if (m_valid) begin
            int h, c, ratio, mode, run, tk, live, ez, ep, ed;
            h = (m_ctl >> 7) & 7;
            c = (m_ctl >> 10) & 7;
            ratio = ((h == 0) ? 1 : 2 * h) * (1 << c);
            mode = m_ctl & 3;
            run = (m_ctl >> 14) & 3;
            tk = (!ctl_wr && m_pre == ratio - 1) ? 1 : 0;
            live = (tk && mode != 3 && run != 0 && !m_halt) ? 1 : 0;
            ez = (live && m_cnt == 0) ? 1 : 0;
            ep = (live && m_cnt == m_act) ? 1 : 0;
            ed = (mode == 1) ? 1 : (mode == 0) ? 0 : m_ud;
            if (rst_n) begin
                checks++;
                if (int'(cnt) != m_cnt || int'(evt_zero) != ez || int'(evt_period) != ep || int'(dir_down) != ed) begin
                    errors++;
                    $display("FAIL %s cycle compare: cnt=%0d z=%0d p=%0d d=%0d expected cnt=%0d z=%0d p=%0d d=%0d",
                             phase, cnt, evt_zero, evt_period, dir_down, m_cnt, ez, ep, ed);
                end
            end
            n_pre = (ctl_wr || tk) ? 0 : m_pre + 1;
            n_ctl = ctl_wr ? int'(ctl_wdata) : m_ctl;
            n_cnt = m_cnt;
            n_ud = m_ud;
            if (live) begin
                if (mode == 0) n_cnt = (m_cnt >= m_act) ? 0 : m_cnt + 1;
                else if (mode == 1) n_cnt = (m_cnt == 0) ? m_act : m_cnt - 1;
                else if (m_ud == 0) begin
                    if (m_cnt >= m_act) begin n_ud = 1; n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                    else n_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin n_ud = 0; n_cnt = (m_act == 0) ? 0 : 1; end
                    else n_cnt = m_cnt - 1;
                end
            end
            if (ctl_wr) n_halt = 0;
            else if (live && run == 1 && n_cnt == 0) n_halt = 1;
            else n_halt = m_halt;
            n_sh = prd_wr ? int'(prd_wdata) : m_sh;
            n_act = m_act;
            if (prd_wr && ((m_ctl >> 3) & 1) == 1) n_act = int'(prd_wdata);
            else if (ez && ((m_ctl >> 3) & 1) == 0) n_act = m_sh;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 1;
            m_ctl = 0; m_pre = 0; m_sh = 0; m_act = 0; m_cnt = 0; m_ud = 0; m_halt = 0;
        end else if (m_valid) begin
            m_ctl = n_ctl; m_pre = n_pre; m_sh = n_sh; m_act = n_act;
            m_cnt = n_cnt; m_ud = n_ud; m_halt = n_halt;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(posedge clk); #1;
        ctl_wr = 1'b0;
    endtask

    task automatic wr_prd(input logic [15:0] v);
        prd_wr = 1'b1; prd_wdata = v;
        @(posedge clk); #1;
        prd_wr = 1'b0;
    endtask

    // Cycles between two successive counter changes.
    task automatic gap(output int g);
        int prev, lim;
        @(negedge clk); prev = int'(cnt); lim = 0;
        while (int'(cnt) == prev && lim < 6000) begin @(negedge clk); lim++; end
        prev = int'(cnt); g = 0;
        while (int'(cnt) == prev && g < 6000) begin @(negedge clk); g++; end
        @(posedge clk); #1;
    endtask

    // Count events and falling cycles over n cycles.
    task automatic watch(input int n, output int nz, output int np, output int nd, output int last_p);
        nz = 0; np = 0; nd = 0; last_p = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (evt_zero) nz++;
            if (evt_period) begin np++; last_p = int'(cnt); end
            if (dir_down) nd++;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired in %s", phase);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int g, nz, np, nd, lp, hold;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        phase = "R1";
        check(cnt == 0 && !evt_zero && !evt_period && !dir_down, "R1 reset state", int'(cnt), 0);
        @(posedge clk); #1;

        phase = "R2";
        wr_ctl(16'hC008); wr_prd(16'd100);
        gap(g); check(g == 1, "R2 ratio 1", g, 1);
        wr_ctl(16'hC588);
        gap(g); check(g == 12, "R2 ratio 12", g, 12);

        phase = "R3";
        wr_ctl(16'hC008); wr_prd(16'd5); idle(8);
        watch(30, nz, np, nd, lp);
        check(nz == 5, "R3 zero events up", nz, 5);
        check(np == 5 && lp == 5, "R9 period events up", np, 5);

        phase = "R4";
        wr_ctl(16'hC089); idle(6);
        watch(24, nz, np, nd, lp);
        check(nz == 2 && np == 2, "R4 events down ratio 2", nz + np, 4);
        check(nd == 24, "R4 dir flag", nd, 24);

        phase = "R5";
        wr_ctl(16'hC00A); wr_prd(16'd4); idle(10);
        watch(40, nz, np, nd, lp);
        check(nz == 5 && np == 5, "R5 events up-down", nz + np, 10);
        check(nd == 20, "R5 falling cycles", nd, 20);

        phase = "R6";
        wr_ctl(16'hC00B);
        hold = int'(cnt);
        watch(20, nz, np, nd, lp);
        check(int'(cnt) == hold && nz == 0 && np == 0, "R6 freeze", int'(cnt), hold);

        phase = "R8";
        wr_ctl(16'hC008); wr_prd(16'd20); idle(25);
        wr_ctl(16'hC000);
        while (cnt != 16'd10) @(negedge clk);
        @(posedge clk); #1;
        wr_prd(16'd6);
        watch(12, nz, np, nd, lp);
        check(lp == 20, "R8 shadow not yet active", lp, 20);
        watch(12, nz, np, nd, lp);
        check(lp == 6, "R8 shadow taken at zero", lp, 6);

        phase = "R7";
        wr_ctl(16'h4008); idle(20);
        check(cnt == 0, "R7 run to end halts at 0", int'(cnt), 0);
        watch(10, nz, np, nd, lp);
        check(cnt == 0 && nz == 0 && np == 0, "R7 halted no events", nz + np, 0);
        wr_ctl(16'hC008); idle(3);
        wr_ctl(16'h0008);
        hold = int'(cnt);
        idle(10);
        check(int'(cnt) == hold, "R7 halt now", int'(cnt), hold);

        phase = "R10";
        wr_ctl(16'hC208);
        hold = int'(cnt);
        for (int k = 0; k < 10; k++) begin idle(4); wr_ctl(16'hC208); end
        check(int'(cnt) == hold, "R10 restart blocks ticks", int'(cnt), hold);
        idle(20);
        check(int'(cnt) != hold, "R10 runs after writes stop", int'(cnt), hold + 2);

        phase = "R2";
        wr_ctl(16'hDF88);
        gap(g); check(g == 1792, "R2 largest ratio", g, 1792);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule